// File: doc/BRIEF.md
# Line-Diamond Search Point Controller

This controller sequences a motion search over a bounded, signed search window. A search runs in rounds. In each round the controller puts up to five candidate motion vectors on its slot outputs, one slot for each SAD unit, and marks which slots are live. It raises a one-cycle launch strobe and then waits for the five SAD results to come back together. It ranks the results and decides where to search next. The first round is a small diamond: the window centre and its four nearest neighbours. If a neighbour wins, the search commits to that neighbour's horizontal or vertical line. Each later round probes the three next points beyond the furthest point already tried on that line.

The search ends in one of four ways: the held best point is not beaten, the next point on the line falls outside the window, an iteration cap is reached, or the diamond centre wins outright. The controller then raises a one-cycle done pulse and holds the final vector and its SAD until the next start. The SAD arithmetic sits outside this block; the block only sees the five SAD values.

Top module: `ld_search_ctrl`

## Requirements
- R1: While reset is held and after it is released, launch, done and every slot-valid bit are low.
- R2: A start pulse in idle gives launch in the following cycle with all five slots valid. The slots carry slot0 = (0,0), slot1 = (-1,0), slot2 = (+1,0), slot3 = (0,-1) and slot4 = (0,+1), as (x,y) with y growing downward.
- R3: If slot0 of the diamond round has the lowest SAD, done follows with vector (0,0) after exactly one launch.
- R4: Ranking goes from slot0 upward, and only a strictly smaller SAD displaces an earlier one. The centre therefore beats an equal neighbour, and a lower slot beats an equal higher slot.
- R5: When a diamond neighbour wins, the step d toward that neighbour becomes the line direction. The next round issues winner+1d, winner+2d and winner+3d on slots 0 to 2, and slots 3 and 4 are not valid.
- R6: Each line round starts one step past the furthest point issued so far, so no point is issued twice. The best point moves only to a slot whose SAD is strictly below the held best. A round with no such slot ends the search.
- R7: A candidate with either coordinate outside [-RANGE, +RANGE] is issued with its valid bit low, and its SAD never takes part in ranking.
- R8: When the point one step past the new frontier lies outside the window, the search ends without a further launch.
- R9: After MAX_ITER line rounds the search ends, even if the line could continue.
- R10: done is high for exactly one cycle. The final vector and SAD stay steady afterwards, and a start seen while a search is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored unless idle) |
| fb_vld | input | 1 | SAD results for the last launch are present |
| fb_sad | input | 5*SAD_W | SAD of slot i at bits [i*SAD_W +: SAD_W] |
| cand_x | output | 5*MV_W | Signed horizontal component of slot i |
| cand_y | output | 5*MV_W | Signed vertical component of slot i |
| cand_vld | output | 5 | Slot i holds a live candidate (bit i) |
| launch | output | 1 | One-cycle strobe: candidates are valid |
| done | output | 1 | One-cycle pulse: search finished |
| best_x | output | MV_W | Final horizontal component |
| best_y | output | MV_W | Final vertical component |
| best_sad | output | SAD_W | SAD at the final vector |

## Verification
The main instance is built with RANGE=5 and MAX_ITER=8. With a window that small, the second line round straddles the edge: one slot is live and two are masked. A target placed beyond the edge therefore shows that masked slots are ignored, and another target shows the range stop. A second instance is built with RANGE=8 and MAX_ITER=1, so the iteration cap ends a search that the window alone would let go on. The bench answers each launch from a distance cost around a target point. Tie cases come from flat costs and from diagonal targets.

// File: rtl/ld_search_pkg.sv
package ld_search_pkg;

  localparam int NSLOT      = 5;
  localparam int LINE_SLOTS = 3;
  localparam logic [2:0] NO_WIN = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} srch_st_e;

  // window membership test on plain integers
  function automatic logic pt_ok(input int x, input int y, input int r);
    return (x >= -r) && (x <= r) && (y >= -r) && (y <= r);
  endfunction

  // diamond offsets, slot order is the ranking order
  function automatic int dia_dx(input int slot);
    return (slot == 1) ? -1 : (slot == 2) ? 1 : 0;
  endfunction

  function automatic int dia_dy(input int slot);
    return (slot == 3) ? -1 : (slot == 4) ? 1 : 0;
  endfunction

endpackage

// File: rtl/ld_pattern_gen.sv
module ld_pattern_gen
  import ld_search_pkg::*;
#(
  parameter int WW    = 8,
  parameter int RANGE = 16
) (
  input  logic                 line_mode,
  input  logic signed [WW-1:0] fx,
  input  logic signed [WW-1:0] fy,
  input  logic signed [1:0]    dx,
  input  logic signed [1:0]    dy,
  output logic signed [WW-1:0] pt_x [NSLOT],
  output logic signed [WW-1:0] pt_y [NSLOT],
  output logic [NSLOT-1:0]     mask
);

  logic signed [WW-1:0] dxw, dyw;
  assign dxw = WW'(dx);
  assign dyw = WW'(dy);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic signed [WW-1:0] STEP = WW'(i + 1);
    always_comb begin
      if (line_mode) begin
        if (i < LINE_SLOTS) begin
          pt_x[i] = fx + dxw * STEP;
          pt_y[i] = fy + dyw * STEP;
          mask[i] = pt_ok(int'(pt_x[i]), int'(pt_y[i]), RANGE);
        end else begin
          pt_x[i] = '0;
          pt_y[i] = '0;
          mask[i] = 1'b0;
        end
      end else begin
        pt_x[i] = WW'(dia_dx(i));
        pt_y[i] = WW'(dia_dy(i));
        mask[i] = pt_ok(dia_dx(i), dia_dy(i), RANGE);
      end
    end
  end

endmodule

// File: rtl/ld_rank_sel.sv
module ld_rank_sel
  import ld_search_pkg::*;
#(
  parameter int SAD_W = 16
) (
  input  logic [NSLOT*SAD_W-1:0] sad_flat,
  input  logic [NSLOT-1:0]       mask,
  input  logic                   use_held,
  input  logic [SAD_W-1:0]       held_sad,
  output logic [2:0]             win_idx,
  output logic [SAD_W-1:0]       win_sad
);

  logic             have;
  logic [SAD_W-1:0] cur;

  // earlier slot keeps a tie; held best ranks ahead of every slot
  always_comb begin
    have    = use_held;
    cur     = held_sad;
    win_idx = NO_WIN;
    for (int i = 0; i < NSLOT; i++) begin
      if (mask[i] && (!have || sad_flat[i*SAD_W +: SAD_W] < cur)) begin
        have    = 1'b1;
        cur     = sad_flat[i*SAD_W +: SAD_W];
        win_idx = 3'(i);
      end
    end
    win_sad = cur;
  end

endmodule

// File: rtl/ld_search_ctrl.sv
module ld_search_ctrl
  import ld_search_pkg::*;
#(
  parameter int MV_W     = 6,
  parameter int SAD_W    = 16,
  parameter int RANGE    = 16,
  parameter int MAX_ITER = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   fb_vld,
  input  logic [NSLOT*SAD_W-1:0] fb_sad,
  output logic [NSLOT*MV_W-1:0]  cand_x,
  output logic [NSLOT*MV_W-1:0]  cand_y,
  output logic [NSLOT-1:0]       cand_vld,
  output logic                   launch,
  output logic                   done,
  output logic [MV_W-1:0]        best_x,
  output logic [MV_W-1:0]        best_y,
  output logic [SAD_W-1:0]       best_sad
);

  localparam int WW = MV_W + 2;
  localparam int IW = $clog2(MAX_ITER + 1);

  srch_st_e             st_q;
  logic                 line_q;
  logic signed [WW-1:0] fx_q, fy_q, cx_q, cy_q;
  logic signed [1:0]    dx_q, dy_q;
  logic [SAD_W-1:0]     held_q;
  logic [IW-1:0]        iter_q;

  logic signed [WW-1:0] pt_x [NSLOT];
  logic signed [WW-1:0] pt_y [NSLOT];
  logic [NSLOT-1:0]     mask;
  logic [2:0]           win_idx, sel;
  logic [SAD_W-1:0]     win_sad;

  ld_pattern_gen #(.WW(WW), .RANGE(RANGE)) u_pat (
    .line_mode(line_q), .fx(fx_q), .fy(fy_q), .dx(dx_q), .dy(dy_q),
    .pt_x(pt_x), .pt_y(pt_y), .mask(mask)
  );

  ld_rank_sel #(.SAD_W(SAD_W)) u_rank (
    .sad_flat(fb_sad), .mask(mask), .use_held(line_q), .held_sad(held_q),
    .win_idx(win_idx), .win_sad(win_sad)
  );

  // named events for the checks
  logic ev_result, ev_centre, ev_improve, ev_cap;
  logic signed [WW-1:0] wx, wy, nd_x, nd_y, nl_fx, nl_fy;

  assign sel        = (win_idx < 3'(NSLOT)) ? win_idx : 3'd0;
  assign wx         = pt_x[sel];
  assign wy         = pt_y[sel];
  assign ev_result  = (st_q == ST_WAIT) && fb_vld;
  assign ev_centre  = ev_result && !line_q && (win_idx == 3'd0);
  assign ev_improve = ev_result && line_q && (win_idx != NO_WIN);
  assign ev_cap     = (iter_q == IW'(MAX_ITER - 1));
  assign nd_x       = wx + wx;                  // one step past the diamond winner
  assign nd_y       = wy + wy;
  assign nl_fx      = fx_q + WW'(dx_q) * WW'(3);
  assign nl_fy      = fy_q + WW'(dy_q) * WW'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      line_q <= 1'b0;
      fx_q   <= '0;  fy_q <= '0;
      cx_q   <= '0;  cy_q <= '0;
      dx_q   <= '0;  dy_q <= '0;
      held_q <= '0;
      iter_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_ISSUE;
          line_q <= 1'b0;
          fx_q   <= '0;  fy_q <= '0;
          dx_q   <= '0;  dy_q <= '0;
          iter_q <= '0;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (fb_vld) begin
          if (!line_q) begin
            cx_q   <= wx;  cy_q <= wy;
            held_q <= win_sad;
            if (win_idx == 3'd0) begin
              st_q <= ST_FIN;
            end else begin
              line_q <= 1'b1;
              dx_q   <= wx[1:0];  dy_q <= wy[1:0];
              fx_q   <= wx;       fy_q <= wy;
              st_q   <= pt_ok(int'(nd_x), int'(nd_y), RANGE) ? ST_ISSUE : ST_FIN;
            end
          end else if (win_idx == NO_WIN) begin
            st_q <= ST_FIN;
          end else begin
            cx_q   <= wx;  cy_q <= wy;
            held_q <= win_sad;
            fx_q   <= nl_fx;  fy_q <= nl_fy;
            iter_q <= iter_q + 1'b1;
            if (ev_cap)
              st_q <= ST_FIN;
            else
              st_q <= pt_ok(int'(nl_fx + WW'(dx_q)), int'(nl_fy + WW'(dy_q)), RANGE)
                      ? ST_ISSUE : ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign launch   = (st_q == ST_ISSUE);
  assign done     = (st_q == ST_FIN);
  assign cand_vld = launch ? mask : '0;
  assign best_x   = cx_q[MV_W-1:0];
  assign best_y   = cy_q[MV_W-1:0];
  assign best_sad = held_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_out
    assign cand_x[i*MV_W +: MV_W] = pt_x[i][MV_W-1:0];
    assign cand_y[i*MV_W +: MV_W] = pt_y[i][MV_W-1:0];
  end

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> (launch && cand_vld == {NSLOT{1'b1}}));
  // R3
  centre_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_centre |=> (done && best_x == '0 && best_y == '0));
  // R5
  slot0_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cand_vld[0]);
  // R6
  improve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_improve |=> (held_q < $past(held_q)));
  // R7
  best_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pt_ok(int'(cx_q), int'(cy_q), RANGE));
  // R9
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(iter_q) <= MAX_ITER);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && $stable(best_x) && $stable(best_y)));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && start && !fb_vld) |=> (st_q == ST_WAIT));

endmodule

// File: tb/ld_search_ctrl_tb.sv
module ld_search_ctrl_tb_top;

  localparam int MV_W  = 6;
  localparam int SAD_W = 16;
  localparam int NS    = 5;
  localparam int BASE  = 100;
  localparam int NSC   = 9;
  // tx, ty, weight, exp_x, exp_y, exp_launches
  localparam int SC [NSC][6] = '{
    '{ 0,  0, 1,  0,  0, 1},
    '{ 0,  0, 0,  0,  0, 1},
    '{ 3,  0, 1,  3,  0, 3},
    '{ 2,  2, 1,  2,  0, 3},
    '{ 0, -3, 1,  0, -3, 3},
    '{-5,  0, 1, -5,  0, 3},
    '{ 9,  0, 1,  5,  0, 3},
    '{ 0,  4, 1,  0,  4, 3},
    '{ 1,  5, 2,  1,  0, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_lim = 1'b0, fb_vld = 1'b0;
  logic [NS*SAD_W-1:0] fb_sad = '0;

  logic [NS*MV_W-1:0] cx, cy, lcx, lcy;
  logic [NS-1:0]      cv, lcv;
  logic               launch, done, l_launch, l_done;
  logic [MV_W-1:0]    bx, by, lbx, lby;
  logic [SAD_W-1:0]   bs, lbs;

  int checks = 0, fails = 0, cyc = 0;
  int rec_x [4][NS];
  int rec_y [4][NS];
  logic [NS-1:0] rec_v [4];

  always #5 clk = ~clk;

  ld_search_ctrl #(.MV_W(MV_W), .SAD_W(SAD_W), .RANGE(5), .MAX_ITER(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_vld(fb_vld), .fb_sad(fb_sad),
    .cand_x(cx), .cand_y(cy), .cand_vld(cv), .launch(launch), .done(done),
    .best_x(bx), .best_y(by), .best_sad(bs));

  ld_search_ctrl #(.MV_W(MV_W), .SAD_W(SAD_W), .RANGE(8), .MAX_ITER(1)) dut_lim_i (
    .clk(clk), .rst_n(rst_n), .start(start_lim), .fb_vld(fb_vld), .fb_sad(fb_sad),
    .cand_x(lcx), .cand_y(lcy), .cand_vld(lcv), .launch(l_launch), .done(l_done),
    .best_x(lbx), .best_y(lby), .best_sad(lbs));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int tx, input int ty, input int w, input bit sel,
                     input bit poke, output int nl, output int rx, output int ry,
                     output int rs);
    bit fin = 0;
    int guard = 0;
    nl = 0; rx = 0; ry = 0; rs = 0;
    @(negedge clk);
    if (sel) start_lim = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; start_lim = 1'b0;
    while (!fin && guard < 200) begin
      guard++;
      if (sel ? l_launch : launch) begin
        for (int i = 0; i < NS; i++) begin
          int x, y;
          x = sel ? int'($signed(lcx[i*MV_W +: MV_W])) : int'($signed(cx[i*MV_W +: MV_W]));
          y = sel ? int'($signed(lcy[i*MV_W +: MV_W])) : int'($signed(cy[i*MV_W +: MV_W]));
          if (nl < 4) begin rec_x[nl][i] = x; rec_y[nl][i] = y; end
          fb_sad[i*SAD_W +: SAD_W] = SAD_W'(w * (iabs(x - tx) + iabs(y - ty)) + BASE);
        end
        if (nl < 4) rec_v[nl] = sel ? lcv : cv;
        nl++;
        @(negedge clk);
        if (poke && nl == 1) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
        fb_vld = 1'b1;
        @(negedge clk);
        fb_vld = 1'b0;
      end else if (sel ? l_done : done) begin
        fin = 1;
        rx = sel ? int'($signed(lbx)) : int'($signed(bx));
        ry = sel ? int'($signed(lby)) : int'($signed(by));
        rs = sel ? int'(lbs) : int'(bs);
      end else begin
        @(negedge clk);
      end
    end
    chk(fin, "R10 search finished", int'(fin), 1);
  endtask

  initial begin
    int nl, rx, ry, rs, hx;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!launch && !done && cv == '0, "R1 outputs in reset", int'({launch, done, cv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!launch && !done && cv == '0 && !l_launch && !l_done,
        "R1 outputs after reset", int'({launch, done, cv}), 0);

    for (int s = 0; s < NSC; s++) begin
      run(SC[s][0], SC[s][1], SC[s][2], 1'b0, 1'b0, nl, rx, ry, rs);
      chk(rx == SC[s][3], $sformatf("R6 scenario %0d final x", s), rx, SC[s][3]);
      chk(ry == SC[s][4], $sformatf("R6 scenario %0d final y", s), ry, SC[s][4]);
      chk(nl == SC[s][5], $sformatf("R6 scenario %0d launches", s), nl, SC[s][5]);
      chk(rs == SC[s][2] * (iabs(SC[s][3] - SC[s][0]) + iabs(SC[s][4] - SC[s][1])) + BASE,
          $sformatf("R6 scenario %0d final sad", s), rs,
          SC[s][2] * (iabs(SC[s][3] - SC[s][0]) + iabs(SC[s][4] - SC[s][1])) + BASE);
      if (s == 0) begin
        // R2 diamond layout
        chk(rec_v[0] == 5'b11111, "R2 diamond mask", int'(rec_v[0]), 31);
        for (int i = 0; i < NS; i++) begin
          int ex, ey;
          ex = (i == 1) ? -1 : (i == 2) ? 1 : 0;
          ey = (i == 3) ? -1 : (i == 4) ? 1 : 0;
          chk(rec_x[0][i] == ex && rec_y[0][i] == ey, $sformatf("R2 diamond slot %0d x", i),
              rec_x[0][i], ex);
        end
      end
      if (s == 1) chk(rx == 0 && ry == 0, "R3 R4 flat cost keeps centre", rx, 0);
      if (s == 3) begin
        // R4 right beats equal down; R5 line slots
        chk(ry == 0, "R4 lower slot wins tie", ry, 0);
        chk(rec_v[1] == 5'b00111, "R5 line mask", int'(rec_v[1]), 7);
        for (int k = 0; k < 3; k++)
          chk(rec_x[1][k] == 2 + k && rec_y[1][k] == 0, $sformatf("R5 line slot %0d x", k),
              rec_x[1][k], 2 + k);
      end
      if (s == 5) begin
        chk(rec_x[2][0] == -5, "R6 frontier not reissued", rec_x[2][0], -5);
        chk(rec_v[2] == 5'b00001, "R7 edge mask", int'(rec_v[2]), 1);
        chk(nl == 3, "R8 range stop without launch", nl, 3);
      end
      if (s == 6) chk(rx == 5, "R7 masked slot sad ignored", rx, 5);
    end

    // R10 done is a single-cycle pulse, result held
    run(0, 4, 1, 1'b0, 1'b0, nl, rx, ry, rs);
    hx = int'($signed(by));
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'($signed(by)) == hx && hx == 4, "R10 result held", int'($signed(by)), 4);

    // R10 start in flight ignored
    run(2, 2, 1, 1'b0, 1'b1, nl, rx, ry, rs);
    chk(rx == 2 && ry == 0 && nl == 3, "R10 busy start ignored", rx * 100 + nl, 203);
    @(negedge clk);
    chk(!launch, "R10 no restart after busy start", int'(launch), 0);

    // R9 iteration cap on the second instance
    run(6, 0, 1, 1'b1, 1'b0, nl, rx, ry, rs);
    chk(rx == 4 && ry == 0, "R9 capped final x", rx, 4);
    chk(nl == 2, "R9 capped launches", nl, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule